// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is the boundary scan register that sits between a device's core logic and its pins. Each pin has a cell with two stages. A capture/shift stage records the pin states and moves them serially from `tdi` to `tdo`. An update stage, loaded on the falling test-clock edge, holds values that can later be driven onto the output pins. A test access port controller (not part of this block) supplies the capture, shift and update strobes, a drive-select flag for the external-test and clamp instructions, and an output-kill flag.

The cell stage is written as a small operation decoder with three named operations. OP_HOLD keeps the cells. OP_CAPTURE loads every cell from its pin or from the system signal that feeds it. OP_SHIFT moves the chain one place toward `tdo`. Every rising edge chooses one operation from the strobes: capture wins when asserted, shift applies when asserted alone, and hold applies otherwise. The pad path has two named states. PATH_SYSTEM passes `sys_out`/`sys_oe` to the pads. PATH_TEST drives the pads from the update cells. `drive_sel` chooses between them combinationally in every cycle. Sampling in PATH_SYSTEM does not disturb the pads, and a preload (shift in, then update, with `tdo` ignored) sets up the values that PATH_TEST will apply later.

Top module: `bsr_chain`

## Requirements
- R1: On a rising `tck` edge with `cap_en` high, input cell i (chain position i, for 0 ≤ i < N_IN) loads `pin_in[i]`.
- R2: On the same capture edge, the data cell of output j (position N_IN+2j) loads `sys_out[j]`, and its enable cell (position N_IN+2j+1) loads `sys_oe[j]`.
- R3: On a rising edge with `shift_en` high and `cap_en` low, every cell takes the value of its neighbour one position higher, and position LEN-1 takes `tdi`. `tdo` always shows position 0 with no register delay.
- R4: Capture has priority over shift. With both strobes low, the cells hold their values.
- R5: On a falling `tck` edge with `upd_en` high, every update cell loads its capture/shift cell. On other falling edges the update cells keep their values.
- R6: With `drive_sel` low, `pad_out` equals `sys_out` and `pad_oe` equals `sys_oe` masked by `oe_kill`. Capture, shift and update activity has no effect on the pads.
- R7: With `drive_sel` high, `pad_out[j]` equals update cell N_IN+2j and `pad_oe[j]` equals update cell N_IN+2j+1 (masked by `oe_kill`).
- R8: With `oe_kill` high, every bit of `pad_oe` is 0 in both paths, and `pad_out` is unaffected.
- R9: While `trst_n` is low, all capture/shift cells and all update cells are 0, independent of the clock.
- R10: After a capture, the bits leave `tdo` in chain order: input pins 0..N_IN-1 first, then each output j from 0 upward as its data bit followed by its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; cells act on the rising edge, update cells on the falling edge |
| trst_n | input | 1 | Asynchronous active-low test reset |
| cap_en | input | 1 | Capture strobe (TAP in Capture-DR with this register selected) |
| shift_en | input | 1 | Shift strobe (Shift-DR) |
| upd_en | input | 1 | Update strobe (Update-DR) |
| tdi | input | 1 | Serial data into the far end of the chain |
| tdo | output | 1 | Serial data out of chain position 0 |
| drive_sel | input | 1 | 1 = pads driven from update cells (external test / clamp) |
| oe_kill | input | 1 | 1 = all pad output enables forced off |
| pin_in | input | N_IN | Pin-side values of the input pins |
| sys_out | input | N_OUT | Core output data before the boundary cells |
| sys_oe | input | N_OUT | Core output enables before the boundary cells |
| pad_out | output | N_OUT | Output data toward the pads |
| pad_oe | output | N_OUT | Output enables toward the pads |

## Verification
Capture and shift results change the chain on a rising edge, and `tdo` shows the new position 0 within the same half period. Update results reach the update cells, and through PATH_TEST the pads, on the falling edge. Changes to `drive_sel`, `oe_kill`, `sys_out` and `sys_oe` pass to the pads with no clock at all. The bench drives strobes just after a rising edge and applies update in its model at the next falling edge. It compares `tdo` and both pad buses one step after that falling edge, and applies capture and shift in its model at the following rising edge, so each comparison sees exactly the edges that have already occurred. The serial ordering is checked separately by reading `tdo` one step after each shift edge.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;

    // Operation applied to the capture/shift stage on a rising edge.
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } bsr_op_e;

    // Source of the pad drive.
    typedef enum logic {
        PATH_SYSTEM = 1'b0,
        PATH_TEST   = 1'b1
    } bsr_path_e;

    // Capture wins over shift; neither strobe means hold.
    function automatic bsr_op_e pick_op(input logic cap, input logic sh);
        if (cap)     return OP_CAPTURE;
        else if (sh) return OP_SHIFT;
        else         return OP_HOLD;
    endfunction

    function automatic int data_pos(input int n_in, input int j);
        return n_in + 2 * j;
    endfunction

    function automatic int en_pos(input int n_in, input int j);
        return n_in + 2 * j + 1;
    endfunction

endpackage

// File: rtl/bsr_capture_gather.sv
`timescale 1ns/1ps
module bsr_capture_gather
    import bsr_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 3,
    parameter int LEN   = N_IN + 2 * N_OUT
) (
    input  logic [N_IN-1:0]  pin_in,
    input  logic [N_OUT-1:0] sys_out,
    input  logic [N_OUT-1:0] sys_oe,
    output logic [LEN-1:0]   cap_vec
);

    // Input pins occupy the positions nearest tdo.
    for (genvar i = 0; i < N_IN; i++) begin : g_in
        assign cap_vec[i] = pin_in[i];
    end

    // Each output pin owns a data cell followed by an enable cell.
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        localparam int DP = data_pos(N_IN, j);
        localparam int EP = en_pos(N_IN, j);
        assign cap_vec[DP] = sys_out[j];
        assign cap_vec[EP] = sys_oe[j];
    end

endmodule

// File: rtl/bsr_shift_stage.sv
`timescale 1ns/1ps
module bsr_shift_stage
    import bsr_pkg::*;
#(
    parameter int LEN = 10
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           cap_en,
    input  logic           shift_en,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_vec,
    output logic [LEN-1:0] sr_q,
    output logic           tdo
);

    bsr_op_e        op;
    logic [LEN-1:0] sr_d;

    // State register.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) sr_q <= '0;
        else         sr_q <= sr_d;
    end

    // Next-state selection by operation.
    always_comb begin
        op   = pick_op(cap_en, shift_en);
        sr_d = sr_q;
        unique case (op)
            OP_CAPTURE: sr_d = cap_vec;
            OP_SHIFT:   sr_d = {tdi, sr_q[LEN-1:1]};
            OP_HOLD:    sr_d = sr_q;
            default:    sr_d = sr_q;
        endcase
    end

    assign tdo = sr_q[0];

    AST_CAPTURE_LOAD: assert property (@(posedge tck) disable iff (!trst_n)
        cap_en |=> (sr_q == $past(cap_vec))); // R1

    AST_SHIFT_STEP: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_en && !cap_en) |=> (sr_q == {$past(tdi), $past(sr_q[LEN-1:1])})); // R3

    AST_IDLE_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (!shift_en && !cap_en) |=> $stable(sr_q)); // R4

endmodule

// File: rtl/bsr_update_stage.sv
`timescale 1ns/1ps
module bsr_update_stage #(
    parameter int LEN = 10
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           upd_en,
    input  logic [LEN-1:0] sr_q,
    output logic [LEN-1:0] upd_q
);

    // Update cells load on the falling edge, half a period after the last shift.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)     upd_q <= '0;
        else if (upd_en) upd_q <= sr_q;
    end

    AST_UPD_HOLD: assert property (@(negedge tck) disable iff (!trst_n)
        !upd_en |=> $stable(upd_q)); // R5

endmodule

// File: rtl/bsr_pad_mux.sv
`timescale 1ns/1ps
module bsr_pad_mux
    import bsr_pkg::*;
#(
    parameter int N_OUT = 3
) (
    input  logic               drive_sel,
    input  logic               oe_kill,
    input  logic [2*N_OUT-1:0] upd_out,
    input  logic [N_OUT-1:0]   sys_out,
    input  logic [N_OUT-1:0]   sys_oe,
    output logic [N_OUT-1:0]   pad_out,
    output logic [N_OUT-1:0]   pad_oe
);

    bsr_path_e path;
    assign path = drive_sel ? PATH_TEST : PATH_SYSTEM;

    for (genvar j = 0; j < N_OUT; j++) begin : g_pad
        logic dval;
        logic eval;
        always_comb begin
            unique case (path)
                PATH_SYSTEM: begin dval = sys_out[j];     eval = sys_oe[j];       end
                PATH_TEST:   begin dval = upd_out[2*j];   eval = upd_out[2*j+1];  end
                default:     begin dval = sys_out[j];     eval = sys_oe[j];       end
            endcase
        end
        assign pad_out[j] = dval;
        assign pad_oe[j]  = eval & ~oe_kill;
    end

endmodule

// File: rtl/bsr_chain.sv
`timescale 1ns/1ps
module bsr_chain #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 3
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             cap_en,
    input  logic             shift_en,
    input  logic             upd_en,
    input  logic             tdi,
    output logic             tdo,
    input  logic             drive_sel,
    input  logic             oe_kill,
    input  logic [N_IN-1:0]  pin_in,
    input  logic [N_OUT-1:0] sys_out,
    input  logic [N_OUT-1:0] sys_oe,
    output logic [N_OUT-1:0] pad_out,
    output logic [N_OUT-1:0] pad_oe
);

    localparam int LEN = N_IN + 2 * N_OUT;

    logic [LEN-1:0] cap_vec;
    logic [LEN-1:0] sr_q;
    logic [LEN-1:0] upd_q;

    bsr_capture_gather #(.N_IN(N_IN), .N_OUT(N_OUT), .LEN(LEN)) u_gather (
        .pin_in  (pin_in),
        .sys_out (sys_out),
        .sys_oe  (sys_oe),
        .cap_vec (cap_vec)
    );

    bsr_shift_stage #(.LEN(LEN)) u_shift (
        .tck      (tck),
        .trst_n   (trst_n),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .tdi      (tdi),
        .cap_vec  (cap_vec),
        .sr_q     (sr_q),
        .tdo      (tdo)
    );

    bsr_update_stage #(.LEN(LEN)) u_update (
        .tck    (tck),
        .trst_n (trst_n),
        .upd_en (upd_en),
        .sr_q   (sr_q),
        .upd_q  (upd_q)
    );

    bsr_pad_mux #(.N_OUT(N_OUT)) u_mux (
        .drive_sel (drive_sel),
        .oe_kill   (oe_kill),
        .upd_out   (upd_q[LEN-1:N_IN]),
        .sys_out   (sys_out),
        .sys_oe    (sys_oe),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    AST_UPD_LOAD: assert property (@(negedge tck) disable iff (!trst_n)
        upd_en |=> (upd_q == $past(sr_q))); // R5

    AST_OE_KILLED: assert property (@(posedge tck) disable iff (!trst_n)
        oe_kill |-> (pad_oe == '0)); // R8

    AST_SYS_PASS: assert property (@(posedge tck) disable iff (!trst_n)
        (!drive_sel && !oe_kill) |-> (pad_out == sys_out && pad_oe == sys_oe)); // R6

endmodule

// File: tb/tb_bsr_chain.sv
`timescale 1ns/1ps
module tb_bsr_chain;

    localparam int N_IN  = 4;
    localparam int N_OUT = 3;
    localparam int LEN   = N_IN + 2 * N_OUT;

    logic             tck = 1'b0;
    logic             trst_n, cap_en, shift_en, upd_en, tdi, tdo;
    logic             drive_sel, oe_kill;
    logic [N_IN-1:0]  pin_in;
    logic [N_OUT-1:0] sys_out, sys_oe, pad_out, pad_oe;

    always #2 tck = ~tck;

    bsr_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) dut (
        .tck(tck), .trst_n(trst_n), .cap_en(cap_en), .shift_en(shift_en),
        .upd_en(upd_en), .tdi(tdi), .tdo(tdo), .drive_sel(drive_sel),
        .oe_kill(oe_kill), .pin_in(pin_in), .sys_out(sys_out),
        .sys_oe(sys_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Behavioural model: chain as a bit array, index 0 at tdo.
    bit m_sr [LEN];
    bit m_upd[LEN];
    bit exp_bits[$];

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        logic [N_OUT-1:0] eo, ee;
        for (int j = 0; j < N_OUT; j++) begin
            eo[j] = drive_sel ? m_upd[N_IN + 2*j]     : sys_out[j];
            ee[j] = oe_kill ? 1'b0 :
                    (drive_sel ? m_upd[N_IN + 2*j + 1] : sys_oe[j]);
        end
        check(tag, "tdo", tdo, m_sr[0]);
        check(tag, "pad_out", pad_out, eo);
        check(tag, "pad_oe", pad_oe, ee);
    endtask

    task automatic model_capture();
        for (int i = 0; i < N_IN; i++) m_sr[i] = pin_in[i];
        for (int j = 0; j < N_OUT; j++) begin
            m_sr[N_IN + 2*j]     = sys_out[j];
            m_sr[N_IN + 2*j + 1] = sys_oe[j];
        end
    endtask

    task automatic model_shift(bit din);
        for (int i = 0; i < LEN - 1; i++) m_sr[i] = m_sr[i+1];
        m_sr[LEN-1] = din;
    endtask

    // One tck period, entered and left just after a rising edge.
    task automatic cyc(bit c, bit s, bit u, bit d, string tag);
        cap_en = c; shift_en = s; upd_en = u; tdi = d;
        @(negedge tck);
        if (u) for (int i = 0; i < LEN; i++) m_upd[i] = m_sr[i];
        #1 compare_all(tag);
        @(posedge tck);
        if (c)      model_capture();
        else if (s) model_shift(d);
        #1;
    endtask

    task automatic do_reset(string tag);
        trst_n = 1'b0;
        for (int i = 0; i < LEN; i++) begin m_sr[i] = 0; m_upd[i] = 0; end
        @(negedge tck);
        #1 compare_all(tag);
        @(posedge tck);
        #1 trst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R3 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        cap_en = 0; shift_en = 0; upd_en = 0; tdi = 0;
        drive_sel = 0; oe_kill = 0;
        pin_in = 4'b1011; sys_out = 3'b101; sys_oe = 3'b110;
        @(posedge tck); #1;
        do_reset("R9");
        drive_sel = 1;
        #1 compare_all("R9");
        drive_sel = 0;

        // Capture then shift out the whole chain; ordering per R10.
        pin_in = 4'b0110; sys_out = 3'b011; sys_oe = 3'b100;
        exp_bits.delete();
        for (int i = 0; i < N_IN; i++) exp_bits.push_back(pin_in[i]);
        for (int j = 0; j < N_OUT; j++) begin
            exp_bits.push_back(sys_out[j]);
            exp_bits.push_back(sys_oe[j]);
        end
        cyc(1, 0, 0, 0, "R1");
        check("R10", "first tdo", tdo, exp_bits[0]);
        for (int k = 0; k < LEN - 1; k++) begin
            cyc(0, 1, 0, k[0], (k < N_IN) ? "R1" : "R2");
            check("R10", "tdo order", tdo, exp_bits[k+1]);
        end

        // Priority and hold.
        pin_in = 4'b1001;
        cyc(1, 1, 0, 1, "R4");
        cyc(0, 0, 0, 1, "R4");
        cyc(0, 0, 0, 0, "R4");

        // Preload while the system path stays transparent.
        for (int k = 0; k < LEN; k++) begin
            sys_out = 3'(k * 5); sys_oe = 3'(k * 3);
            cyc(0, 1, 0, ((k % 3) == 0), "R6");
        end
        cyc(0, 0, 1, 0, "R5");
        sys_out = 3'b010;
        cyc(1, 0, 0, 0, "R6");

        // Apply preloaded values.
        drive_sel = 1;
        cyc(0, 0, 0, 0, "R7");
        for (int k = 0; k < 4; k++) cyc(0, 1, 0, 1, "R5");
        cyc(0, 0, 1, 0, "R7");
        cyc(0, 0, 0, 0, "R7");

        // Output kill in both paths.
        oe_kill = 1;
        cyc(0, 0, 0, 0, "R8");
        drive_sel = 0; sys_oe = 3'b111;
        cyc(0, 0, 0, 0, "R8");
        oe_kill = 0;

        // Reset in the middle of external test.
        drive_sel = 1;
        do_reset("R9");
        cyc(0, 0, 0, 0, "R9");

        // Random traffic.
        for (int k = 0; k < 400; k++) begin
            pin_in    = 4'($urandom);
            sys_out   = 3'($urandom);
            sys_oe    = 3'($urandom);
            drive_sel = ($urandom % 4) == 0;
            oe_kill   = ($urandom % 8) == 0;
            cyc(($urandom % 6) == 0, ($urandom % 2) == 0,
                ($urandom % 5) == 0, 1'($urandom), "R3");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule